// File: doc/BRIEF.md
# Dual Down-Counter Timer with Flag/Enable Interrupt Controller

This block provides two 16-bit down-counting timers and an interrupt flag/enable pair, all reached through a map of sixteen byte-wide registers. The register index comes from address bits [12:9]; every other address bit is ignored. Both timers advance one step per cycle on which the clock-enable input `tick_i` is high. In the target system that enable runs at roughly 4.7 MHz divided by 6.

Timer 1 is a reload timer. Its counter runs down from the loaded value, through zero, to an extra "minus one" step shown as 0xFFFF. It then reloads from a 16-bit latch, so one full period is latch+2 ticks. In continuous mode it raises its flag each time the count reaches zero. Timer 2 is a plain 16-bit down counter that wraps, loaded by a two-byte write sequence.

A seven-bit flag register and a seven-bit enable register drive a single interrupt output. Only the shift-register and timer-1 sources reach that output. The shift-register data byte and the port registers are plain storage. A one-cycle pulse on `sr_done_i` from the neighbouring serial engine marks a shift-register event.

Top module: `dtim_top`

## Requirements
- R1: After reset the register reads are as follows. Indices 4, 5, 6 and 7 read 0xFF, since the timer-1 counter and latch are 0xFFFF. Indices 8 and 9 read 0xFF, since the timer-2 counter is 0xFFFF. Index 14 reads 0x80. Every other index reads 0x00, and `irq_o` is low.
- R2: On each tick the timer-1 counter moves one step down. The step after 0x0000 shows 0xFFFF. The step after that shows the latch value, so the period is latch+2 ticks. A latch of 0xFFFF still gives a period of 0x10001 ticks. Index 4 reads the counter low byte and index 5 reads the high byte.
- R3: Flag bit 6 (timer 1) is set when a tick brings the timer-1 count to zero. This happens only while bits [7:6] of index 11 equal 01. With any other value of those bits the flag is never set by timer 1.
- R4: A write to index 4 or to index 6 replaces the latch low byte. A write to index 5 replaces the latch high byte, clears flag bit 6, and loads the counter with the full new latch. A write to index 7 replaces the high byte and clears flag bit 6, but leaves the counter running.
- R5: A read of index 4 clears flag bit 6. Reads of indices 5, 6 and 7 change no state. Indices 6 and 7 read the latch low and high bytes.
- R6: A write to index 8 stores the byte and loads the timer-2 counter with 0x00 followed by that byte. A write to index 9 loads the counter with {written byte, stored byte}. On each tick the counter decrements modulo 2^16. Flag bit 5 is set when a tick brings the count to zero. A read of index 8 returns the counter low byte and clears bit 5; index 9 reads the counter high byte.
- R7: `irq_o` is high exactly while flag and enable registers share a set bit at bit 2 or bit 6. Bit 5 never drives it.
- R8: A write to index 14 with bit 7 high sets the enable bits written as 1 in bits [6:0]. With bit 7 low it clears those bits. A read of index 14 returns bit 7 as 1 above the enable bits.
- R9: A write to index 13 clears every flag whose bit is written as 1. A read of index 13 returns the flags in bits [6:0], with bit 7 high when any flag is both pending and enabled. In any cycle where a flag is set and cleared at once, the set wins.
- R10: A pulse on `sr_done_i` sets flag bit 2. A read of index 10 clears it.
- R11: Indices 0, 1, 2, 3, 10, 11, 12 and 15 are plain byte storage that reads back the last value written.
- R12: Only address bits [12:9] select the register; bits [8:0] have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer clock enable |
| sr_done_i | input | 1 | Shift-register event pulse, sets flag bit 2 |
| addr_i | input | 13 | Byte address, index in bits [12:9] |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe, side effects at the clock edge |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Interrupt output |

## Verification
The assertions assume that a write and a read strobe last one cycle each and that `tick_i` is a level sampled at the clock edge. They also assume that a load of a counter and a tick in the same cycle resolve in favour of the load, and that inputs are known from time zero. The stimulus drives all inputs to zero before reset is released and changes them only between edges. It mixes directed sequences with random strobes, indices, data and ticks that stay within those rules, including same-cycle set and clear of a flag.

// File: rtl/dtim_pkg.sv
package dtim_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned FW    = 7;
  localparam int unsigned NREG  = 16;

  localparam int unsigned IX_T1_CLO = 4;
  localparam int unsigned IX_T1_CHI = 5;
  localparam int unsigned IX_T1_LLO = 6;
  localparam int unsigned IX_T1_LHI = 7;
  localparam int unsigned IX_T2_LO  = 8;
  localparam int unsigned IX_T2_HI  = 9;
  localparam int unsigned IX_SR     = 10;
  localparam int unsigned IX_MODE   = 11;
  localparam int unsigned IX_FLAG   = 13;
  localparam int unsigned IX_EN     = 14;

  localparam int unsigned FLG_SR = 2;
  localparam int unsigned FLG_T2 = 5;
  localparam int unsigned FLG_T1 = 6;
  localparam logic [FW-1:0] IRQ_MASK = 7'h44;

  function automatic logic is_plain(input int unsigned i);
    return (i <= 3) || (i == IX_SR) || (i == IX_MODE) || (i == 12) || (i == 15);
  endfunction
endpackage

// File: rtl/dtim_reload_timer.sv
module dtim_reload_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic [CW-1:0] latch_i,
  input  logic          cont_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          neg_q, neg_d;  // showing the extra -1 step

  always_comb begin
    if (neg_q) begin
      cnt_d = latch_i;
      neg_d = 1'b0;
    end else if (cnt_q == '0) begin
      cnt_d = '1;
      neg_d = 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
      neg_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      neg_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      neg_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= cnt_d;
      neg_q <= neg_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = tick_i & ~load_i & cont_i & ~neg_d & (cnt_d == '0);

  p_minus_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && !neg_q && cnt_q == '0) |=> (cnt_q == '1 && neg_q));
  p_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && neg_q) |=> (cnt_q == $past(latch_i) && !neg_q));
  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/dtim_free_timer.sv
module dtim_free_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '1;
    else if (load_i)  cnt_q <= load_val_i;
    else if (tick_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = tick_i & ~load_i & (cnt_q == CW'(1));

  p_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dtim_irq_ctl.sv
module dtim_irq_ctl
  import dtim_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [FW-1:0] set_i,
  input  logic [FW-1:0] clr_i,
  input  logic          en_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [FW-1:0] flag_o,
  output logic [FW-1:0] en_o,
  output logic          pend_o,
  output logic          irq_o
);
  logic [FW-1:0] flag_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_i) | set_i;
      if (en_wr_i) begin
        if (wdata_i[DW-1]) en_q <= en_q | wdata_i[FW-1:0];
        else               en_q <= en_q & ~wdata_i[FW-1:0];
      end
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign pend_o = |(flag_q & en_q);
  assign irq_o  = |(flag_q & en_q & IRQ_MASK);

  p_t1_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q[FLG_T1]) |-> $past(set_i[FLG_T1]));
  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0 && set_i == '0) |=> ((flag_q & $past(clr_i)) == '0));
  p_en_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_wr_i && wdata_i[DW-1]) |=> ((en_q & $past(wdata_i[FW-1:0])) == $past(wdata_i[FW-1:0])));
  p_irq_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_q[FLG_SR] || flag_q[FLG_T1]));
endmodule

// File: rtl/dtim_top.sv
module dtim_top
  import dtim_pkg::*;
#(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned IDX_LSB = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sr_done_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              rd_en_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o
);
  localparam int unsigned IW = $clog2(NREG);
  localparam int unsigned CW = 2 * DW;

  logic [IW-1:0] idx;
  assign idx = addr_i[IDX_LSB+IW-1:IDX_LSB];

  logic unused_addr;
  assign unused_addr = ^{addr_i[IDX_LSB-1:0]};

  logic [DW-1:0] store_q [NREG];
  logic [CW-1:0] t1_latch_q;
  logic [DW-1:0] t2_lo_q;

  function automatic logic hit(input logic [IW-1:0] i, input int unsigned n);
    return i == IW'(n);
  endfunction

  // plain storage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) store_q[i] <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < NREG; i++)
        if (is_plain(i) && hit(idx, i)) store_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t1_latch_q <= '1;
      t2_lo_q    <= '0;
    end else if (wr_en_i) begin
      if (hit(idx, IX_T1_CLO) || hit(idx, IX_T1_LLO)) t1_latch_q[DW-1:0]  <= wdata_i;
      if (hit(idx, IX_T1_CHI) || hit(idx, IX_T1_LHI)) t1_latch_q[CW-1:DW] <= wdata_i;
      if (hit(idx, IX_T2_LO))                         t2_lo_q             <= wdata_i;
    end
  end

  logic          t1_load, t2_load, t1_zero, t2_zero, t1_cont;
  logic [CW-1:0] t1_cnt, t2_cnt, t2_val;

  assign t1_cont = store_q[IX_MODE][DW-1:DW-2] == 2'b01;
  assign t1_load = wr_en_i && hit(idx, IX_T1_CHI);
  assign t2_load = wr_en_i && (hit(idx, IX_T2_LO) || hit(idx, IX_T2_HI));
  assign t2_val  = hit(idx, IX_T2_LO) ? {{DW{1'b0}}, wdata_i} : {wdata_i, t2_lo_q};

  dtim_reload_timer #(.CW(CW)) u_t1 (
    .clk_i, .rst_ni, .tick_i,
    .load_i     (t1_load),
    .load_val_i ({wdata_i, t1_latch_q[DW-1:0]}),
    .latch_i    (t1_latch_q),
    .cont_i     (t1_cont),
    .cnt_o      (t1_cnt),
    .zero_o     (t1_zero)
  );

  dtim_free_timer #(.CW(CW)) u_t2 (
    .clk_i, .rst_ni, .tick_i,
    .load_i     (t2_load),
    .load_val_i (t2_val),
    .cnt_o      (t2_cnt),
    .zero_o     (t2_zero)
  );

  logic [FW-1:0] set, clr, flag, en;
  logic          pend;

  always_comb begin
    set = '0;
    set[FLG_T1] = t1_zero;
    set[FLG_T2] = t2_zero;
    set[FLG_SR] = sr_done_i;
    clr = (wr_en_i && hit(idx, IX_FLAG)) ? wdata_i[FW-1:0] : '0;
    if ((wr_en_i && (hit(idx, IX_T1_CHI) || hit(idx, IX_T1_LHI))) ||
        (rd_en_i && hit(idx, IX_T1_CLO))) clr[FLG_T1] = 1'b1;
    if (rd_en_i && hit(idx, IX_T2_LO)) clr[FLG_T2] = 1'b1;
    if (rd_en_i && hit(idx, IX_SR))    clr[FLG_SR] = 1'b1;
  end

  dtim_irq_ctl u_irq (
    .clk_i, .rst_ni,
    .set_i   (set),
    .clr_i   (clr),
    .en_wr_i (wr_en_i && hit(idx, IX_EN)),
    .wdata_i,
    .flag_o  (flag),
    .en_o    (en),
    .pend_o  (pend),
    .irq_o
  );

  always_comb begin
    case (idx)
      IW'(IX_T1_CLO): rdata_o = t1_cnt[DW-1:0];
      IW'(IX_T1_CHI): rdata_o = t1_cnt[CW-1:DW];
      IW'(IX_T1_LLO): rdata_o = t1_latch_q[DW-1:0];
      IW'(IX_T1_LHI): rdata_o = t1_latch_q[CW-1:DW];
      IW'(IX_T2_LO):  rdata_o = t2_cnt[DW-1:0];
      IW'(IX_T2_HI):  rdata_o = t2_cnt[CW-1:DW];
      IW'(IX_FLAG):   rdata_o = {pend, flag};
      IW'(IX_EN):     rdata_o = {1'b1, en};
      default:        rdata_o = store_q[idx];
    endcase
  end

  p_rd_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && hit(idx, IX_T1_CLO) && !t1_zero) |=> !flag[FLG_T1]);
  p_no_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !t1_cont |-> !t1_zero);
endmodule

// File: tb/dtim_top_tb_top.sv
`timescale 1ns/1ps
module dtim_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, srd = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference state
  int t1v, t1l, t2c, t2lo, ifr, ier;
  int plain [16];

  always #2 clk = ~clk;

  dtim_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sr_done_i(srd),
    .addr_i(addr), .wr_en_i(wr), .wdata_i(wdata), .rd_en_i(rd),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(input int i);
    case (i)
      4:  return (t1v < 0 ? 16'hFFFF : t1v) & 255;
      5:  return ((t1v < 0 ? 16'hFFFF : t1v) >> 8) & 255;
      6:  return t1l & 255;
      7:  return (t1l >> 8) & 255;
      8:  return t2c & 255;
      9:  return (t2c >> 8) & 255;
      13: return ifr | (((ifr & ier) != 0) ? 128 : 0);
      14: return ier | 128;
      default: return plain[i];
    endcase
  endfunction

  task automatic model_reset();
    t1v = 65535; t1l = 65535; t2c = 65535; t2lo = 0; ifr = 0; ier = 0;
    for (int i = 0; i < 16; i++) plain[i] = 0;
  endtask

  task automatic model_upd(input bit w, input bit r, input int i, input int d,
                           input bit tk, input bit s);
    int set, clr;
    bit cont;
    set = 0; clr = 0;
    cont = ((plain[11] >> 6) & 3) == 1;
    if (w && i == 5) t1v = (d << 8) | (t1l & 255);
    else if (tk) begin
      t1v = (t1v == -1) ? t1l : t1v - 1;
      if (t1v == 0 && cont) set |= 64;
    end
    if (w && i == 8) t2c = d;
    else if (w && i == 9) t2c = (d << 8) | t2lo;
    else if (tk) begin
      t2c = (t2c - 1) & 16'hFFFF;
      if (t2c == 0) set |= 32;
    end
    if (s) set |= 4;
    if (w && i == 13) clr |= d & 127;
    if (w && (i == 5 || i == 7)) clr |= 64;
    if (r && i == 4) clr |= 64;
    if (r && i == 8) clr |= 32;
    if (r && i == 10) clr |= 4;
    if (w && i == 14) ier = (d & 128) ? (ier | (d & 127)) : (ier & ~d & 127);
    if (w && (i == 4 || i == 6)) t1l = (t1l & 16'hFF00) | d;
    if (w && (i == 5 || i == 7)) t1l = (t1l & 255) | (d << 8);
    if (w && i == 8) t2lo = d;
    if (w && (i <= 3 || i == 10 || i == 11 || i == 12 || i == 15)) plain[i] = d;
    ifr = ((ifr & ~clr) | set) & 127;
  endtask

  // one clock: drive, compare against pre-edge model, advance model
  task automatic step(input bit w, input bit r, input int i, input int d,
                      input bit tk, input bit s, input string tag);
    @(negedge clk);
    wr = w; rd = r; wdata = d[7:0]; tick = tk; srd = s;
    addr = {i[3:0], 9'($urandom)};
    #1;
    chk("R7 irq", int'(irq), ((ifr & ier & 8'h44) != 0) ? 1 : 0);
    if (r) chk(tag, int'(rdata), exp_rd(i));
    @(posedge clk);
    model_upd(w, r, i, d, tk, s);
  endtask

  task automatic wr_reg(input int i, input int d, input string tag);
    step(1, 0, i, d, 0, 0, tag);
  endtask
  task automatic rd_reg(input int i, input string tag);
    step(0, 1, i, 0, 0, 0, tag);
  endtask
  task automatic ticks(input int n, input int ri, input string tag);
    for (int k = 0; k < n; k++) step(0, ri >= 0, ri < 0 ? 0 : ri, 0, 1, 0, tag);
  endtask

  initial begin
    model_reset();
    #10 rst_n = 1'b1;

    // R1 reset values
    for (int i = 0; i < 16; i++) rd_reg(i, "R1 reset read");
    chk("R1 irq low", int'(irq), 0);

    // R11 / R12 plain storage with random low address bits
    foreach (plain[i]) if (i <= 3 || i == 10 || i == 11 || i == 12 || i == 15)
      wr_reg(i, 8'h5A ^ (i * 17), "R11");
    for (int i = 0; i < 16; i++) rd_reg(i, "R12 decode readback");
    rd_reg(10, "R10 sr read");

    // R8 enable set/clear
    wr_reg(14, 8'hFF, "R8");
    rd_reg(14, "R8 set all");
    wr_reg(14, 8'h1B, "R8");
    rd_reg(14, "R8 clear some");
    wr_reg(14, 8'h7F, "R8");
    rd_reg(14, "R8 clear all");
    wr_reg(14, 8'hC4, "R8");

    // R2 / R3 continuous timer 1, latch 3
    wr_reg(11, 8'h40, "R3");
    wr_reg(6, 3, "R4");
    wr_reg(5, 0, "R4 load");
    rd_reg(5, "R4 high after load");
    ticks(12, 5, "R2 count high");
    rd_reg(13, "R3 flag after zero");
    chk("R3 irq with enable", int'(irq), 1);
    ticks(3, 6, "R5 latch read no effect");
    rd_reg(13, "R5 latch read keeps flag");
    ticks(1, 4, "R5 count low + clear");
    rd_reg(13, "R5 flag cleared by read");
    ticks(9, 4, "R2 count low");

    // R4 write 7 clears without reload
    ticks(2, -1, "R2");
    wr_reg(7, 0, "R4 hi no reload");
    rd_reg(4, "R4 counter kept");
    rd_reg(13, "R4 flag cleared");

    // R3 non-continuous: no flag
    wr_reg(11, 8'hC0, "R3");
    ticks(20, 13, "R3 no flag when mode 11");
    wr_reg(11, 8'h00, "R3");
    ticks(10, 13, "R3 no flag when mode 00");

    // R2 latch 0xFFFF long period (0x10001 ticks)
    wr_reg(11, 8'h40, "R3");
    wr_reg(6, 8'hFF, "R4");
    wr_reg(5, 8'hFF, "R4 load ffff");
    ticks(65535, -1, "R2");
    rd_reg(13, "R2 flag at zero of long period");
    rd_reg(4, "R2 at zero");
    ticks(1, 5, "R2 minus one step");
    ticks(1, 4, "R2 reload ffff");

    // R6 timer 2, bit 5 enabled but not driving irq
    wr_reg(13, 8'h7F, "R9 clear all");
    wr_reg(11, 8'h00, "R3");
    wr_reg(14, 8'hA0, "R7");
    wr_reg(8, 2, "R6 load low");
    rd_reg(9, "R6 high zero");
    ticks(3, 9, "R6 wrap high");
    rd_reg(13, "R6 flag bit5");
    chk("R7 bit5 no irq", int'(irq), 0);
    rd_reg(8, "R6 read low clears");
    rd_reg(13, "R6 flag cleared");
    wr_reg(9, 8'h01, "R6 load 0x0102");
    ticks(4, 8, "R6 count");
    rd_reg(9, "R6 high byte");

    // R10 / R9 shift flag, write-clear and pending bit
    step(0, 0, 0, 0, 0, 1, "R10");
    rd_reg(13, "R10 sr flag set");
    rd_reg(10, "R10 sr read clears");
    rd_reg(13, "R10 cleared");
    step(0, 0, 0, 0, 0, 1, "R10");
    wr_reg(14, 8'h7F, "R8");
    rd_reg(13, "R9 pend low when disabled");
    wr_reg(13, 8'h04, "R9 write clear");
    rd_reg(13, "R9 cleared");
    // set and clear same cycle: set wins
    step(1, 0, 13, 8'h04, 0, 1, "R9");
    rd_reg(13, "R9 set wins");

    // random mix
    for (int k = 0; k < 4000; k++) begin
      int i;
      i = $urandom_range(0, 15);
      step($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1, i,
           $urandom_range(0, 255), $urandom_range(0, 1) == 1,
           $urandom_range(0, 15) == 0, "R9 random read");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule